// File: doc/BRIEF.md
# Mode-Gated Carry Flag for an Accumulator Datapath

This block adds a stored carry bit and a carry-mode switch to a small 8-bit accumulator datapath. The ALU, the fetch logic and the opcode decoder are outside it. The block receives the class of the instruction that executes in the current cycle, already decoded, along with the ALU carry-out and a few control strobes. It returns the carry-in that the ALU must use, and it holds the carry flag.

With carry mode off, the plain add and subtract opcodes behave as they always did. Add gets a carry-in of 0. Subtract gets a carry-in of 1, so that it computes A + ~B + 1. The stored flag is held at 0 and has no effect.

With carry mode on, those same two opcodes take their carry-in from the flag, and they write their carry-out back into it. In this mode they act as add-with-carry and subtract-with-borrow, where for subtract the flag means "no borrow". Every other instruction, conditional branches included, keeps the fixed carry-in that the decoder supplies, whatever the mode.

Top module: `carry_gate_unit`

## Requirements
- R1: After reset the carry flag reads 0 and carry mode is off.
- R2: With carry mode off, the carry-in is 0 for class ADD (code 2'b01) and 1 for class SUB (code 2'b10).
- R3: With carry mode on, the carry-in for class ADD or SUB equals the stored carry flag.
- R4: For class OTHER (code 2'b00) or BRANCH (code 2'b11), the carry-in equals the fixed_cin input, in either mode.
- R5: While carry mode is off, the carry flag stays 0, whatever the ALU carry-out, the instruction class or the set strobe.
- R6: With carry mode on, an ADD or SUB cycle loads the ALU carry-out into the flag at the clock edge that ends the cycle, so the next instruction sees it.
- R7: With carry mode on, an OTHER or BRANCH cycle without the set strobe leaves the flag unchanged.
- R8: With carry mode on, the set strobe makes the flag 1 at the next edge, and it wins over an ADD or SUB in the same cycle.
- R9: A write with mode_wr_data = 0 turns carry mode off and clears the flag at the same edge. A write with value 1 turns carry mode on from the next cycle, and the flag then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 2 | Class of the executing instruction: 00 OTHER, 01 ADD, 10 SUB, 11 BRANCH |
| fixed_cin | input | 1 | Decoder's fixed carry-in for OTHER and BRANCH classes |
| alu_cout | input | 1 | ALU carry-out of the current instruction |
| mode_wr | input | 1 | Strobe that writes the carry-mode bit |
| mode_wr_data | input | 1 | Value written to the carry-mode bit |
| carry_set | input | 1 | Strobe that sets the carry flag (only in carry mode) |
| alu_cin | output | 1 | Carry-in to drive into the ALU |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The carry-in is combinational. The bench reads it in the same cycle as the class and strobes that produce it, a short time after driving them at the falling edge. The flag and the mode bit change only at the rising edge, so an ADD, SUB, set or mode write shows up on carry_flag one cycle later. The bench checks that at the next falling edge, before it drives the next cycle's inputs. Mode changes have no port of their own. The bench observes them one cycle after the write, through the carry-in that ADD and SUB select.

// File: rtl/carry_gate_unit.sv
module carry_gate_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_class,
  input  logic       fixed_cin,
  input  logic       alu_cout,
  input  logic       mode_wr,
  input  logic       mode_wr_data,
  input  logic       carry_set,
  output logic       alu_cin,
  output logic       carry_flag
);

  localparam logic [1:0] CLS_OTHER  = 2'b00;
  localparam logic [1:0] CLS_ADD    = 2'b01;
  localparam logic [1:0] CLS_SUB    = 2'b10;
  localparam logic [1:0] CLS_BRANCH = 2'b11;

  logic mode_q;
  logic carry_q;
  logic is_add, is_sub, is_arith, mode_kill, live;

  assign is_add    = (op_class == CLS_ADD);
  assign is_sub    = (op_class == CLS_SUB);
  assign is_arith  = is_add | is_sub;
  assign mode_kill = mode_wr & ~mode_wr_data;
  assign live      = mode_q & ~mode_kill;

  always_comb begin
    if (is_arith)
      alu_cin = mode_q ? carry_q : is_sub;
    else
      alu_cin = fixed_cin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (mode_wr)
        mode_q <= mode_wr_data;
      if (!live)
        carry_q <= 1'b0;
      else if (carry_set)
        carry_q <= 1'b1;
      else if (is_arith)
        carry_q <= alu_cout;
    end
  end

  assign carry_flag = carry_q;

  a_r5_off_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !carry_flag);

  a_r4_fixed_cin: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_OTHER || op_class == CLS_BRANCH) |-> alu_cin == fixed_cin);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !carry_set && is_arith) |=> carry_flag == $past(alu_cout));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !carry_set && !is_arith) |=> $stable(carry_flag));

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (live && carry_set) |=> carry_flag);

  a_r9_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_kill |=> !carry_flag);

endmodule

// File: tb/carry_gate_unit_tb.sv
module carry_gate_unit_tb;
  logic clk = 0;
  logic rst_n;
  logic [1:0] op_class;
  logic fixed_cin, alu_cout, mode_wr, mode_wr_data, carry_set;
  logic alu_cin, carry_flag;

  int checks = 0;
  int errors = 0;
  bit m_mode, m_carry;

  always #4 clk = ~clk;

  carry_gate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .fixed_cin(fixed_cin),
    .alu_cout(alu_cout), .mode_wr(mode_wr), .mode_wr_data(mode_wr_data),
    .carry_set(carry_set), .alu_cin(alu_cin), .carry_flag(carry_flag)
  );

  function automatic bit exp_cin(bit [1:0] c, bit md, bit cy, bit fx);
    if (c == 2'b01) return md ? cy : 1'b0;
    if (c == 2'b10) return md ? cy : 1'b1;
    return fx;
  endfunction

  function automatic bit exp_next_carry(bit md, bit cy, bit [1:0] c, bit co,
                                        bit mw, bit md_d, bit st);
    if (!md || (mw && !md_d)) return 1'b0;
    if (st) return 1'b1;
    if (c == 2'b01 || c == 2'b10) return co;
    return cy;
  endfunction

  function automatic string cin_tag(bit [1:0] c, bit md);
    if (c == 2'b00 || c == 2'b11) return "R4";
    return md ? "R3" : "R2";
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit [1:0] c, bit fx, bit co, bit mw, bit md_d, bit st,
                      string flag_tag);
    @(negedge clk);
    check(flag_tag, carry_flag, m_carry);
    op_class = c; fixed_cin = fx; alu_cout = co;
    mode_wr = mw; mode_wr_data = md_d; carry_set = st;
    #1;
    check(cin_tag(c, m_mode), alu_cin, exp_cin(c, m_mode, m_carry, fx));
    @(posedge clk);
    m_carry = exp_next_carry(m_mode, m_carry, c, co, mw, md_d, st);
    if (mw) m_mode = md_d;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    rst_n = 0; op_class = 0; fixed_cin = 0; alu_cout = 0;
    mode_wr = 0; mode_wr_data = 0; carry_set = 0;
    m_mode = 0; m_carry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1", carry_flag, 1'b0);

    // R1/R2: mode off after reset
    step(2'b01, 0, 1, 0, 0, 0, "R1");
    step(2'b10, 0, 1, 0, 0, 0, "R5");
    // R5: set strobe and carry-out ignored while off
    step(2'b00, 0, 0, 0, 0, 1, "R5");
    step(2'b01, 1, 1, 0, 0, 0, "R5");
    // R9: enable, flag reads 0
    step(2'b00, 1, 0, 1, 1, 0, "R5");
    step(2'b01, 0, 1, 0, 0, 0, "R9");
    // R6: capture 1 from ADD
    step(2'b10, 0, 0, 0, 0, 0, "R6");
    // R6: SUB captured 0; R8 set
    step(2'b00, 0, 1, 0, 0, 1, "R6");
    // R7: branch holds
    step(2'b11, 1, 0, 0, 0, 0, "R8");
    step(2'b00, 0, 0, 0, 0, 0, "R7");
    // R8: set beats ADD with carry-out 0
    step(2'b01, 0, 0, 0, 0, 1, "R7");
    // R9: disable clears at same edge
    step(2'b01, 0, 1, 1, 0, 0, "R8");
    step(2'b10, 0, 1, 0, 0, 0, "R9");
    step(2'b00, 0, 0, 1, 1, 0, "R5");
    step(2'b10, 0, 1, 0, 0, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      bit [1:0] c;
      bit mw;
      c  = 2'($urandom);
      mw = ($urandom % 16) == 0;
      step(c, 1'($urandom), 1'($urandom), mw, 1'($urandom),
           ($urandom % 8) == 0, m_mode ? "R6" : "R5");
    end

    @(negedge clk);
    check("R7", carry_flag, m_carry);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule